// File: doc/BRIEF.md
# Serial Control and Status Word Port

This block is the serial slave port of a multi-channel switch driver. A host frames each exchange with an active-low select line. It clocks in a 16-bit control word on the serial data input, MSB first. At the same time it clocks out a 16-bit status word on the serial data output. The control word carries one switch command per channel, an enable for shutdown on overcurrent, and a request to clear latched faults. The status word carries the temperature warning, supply failure, open load and short-circuit flags, followed by the output state of each channel.

All serial pins are brought into the system clock domain through synchronizer chains, and all of the protocol logic runs on the system clock. A control word takes effect only when the select line rises after exactly 16 serial clocks. If the host breaks off a frame early or runs it long, the frame leaves no trace. The temperature warning sits in the most significant status position. A host can therefore read that flag alone by dropping select, sampling the data output, and raising select again, without disturbing anything.

Top module: `spi_stat_port`

## Requirements
- R1: While rst_ni is low and right after it is released, ch_on_o and ocs_en_o are all zero, srr_pulse_o is low and sdo_oe_o is low.
- R2: sdo_oe_o is low and sdo_o is 0 while csn_i is high. sdo_oe_o is high while a frame is open (csn_i low).
- R3: Within three clk_i rising edges of csn_i falling, and before any sck_i edge, sdo_o shows tp_i as it was at that moment.
- R4: The status word is sampled once, when select falls, and stays fixed for the whole frame whatever the status inputs do afterwards. Its layout is bit 15 = tp_i, bit 14 = psf_i, bit 13 = opl_i, bit 12 = scd_i, bits 11:0 = ch_stat_i. It is sent MSB first, and the next bit appears after each falling sck_i edge.
- R5: sdi_i is sampled on each rising sck_i edge, MSB first. After a frame of exactly 16 rising edges, the rise of csn_i loads ch_on_o from bits 11:0 and ocs_en_o from bit 14. Bits 13:12 are ignored.
- R6: A frame with fewer than 16 rising sck_i edges changes neither ch_on_o nor ocs_en_o and gives no srr_pulse_o. This includes a frame of zero edges that only reads the temperature flag.
- R7: A frame with more than 16 rising sck_i edges is discarded in the same way.
- R8: A complete frame with bit 15 set raises srr_pulse_o for exactly one clk_i cycle. A complete frame with bit 15 clear raises no pulse.
- R9: sck_i and sdi_i activity while csn_i is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Frame select, active low |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |
| tp_i | input | 1 | Temperature warning flag |
| psf_i | input | 1 | Supply failure flag |
| opl_i | input | 1 | Open load flag |
| scd_i | input | 1 | Short-circuit flag |
| ch_stat_i | input | 12 | Per-channel output state |
| ch_on_o | output | 12 | Latched per-channel switch commands |
| ocs_en_o | output | 1 | Latched overcurrent shutdown enable |
| srr_pulse_o | output | 1 | One-cycle request to clear latched faults |

## Verification
Every pin change passes through two synchronizer flops and then one action register. A result is therefore settled by the third clk_i rising edge after the serial edge or select edge that causes it. This applies to the status bit on sdo_o, the output enable, the control outputs and the start of the clear pulse. The bench holds each serial level for four system clocks and samples on falling clk_i edges at the end of that hold, so every sample falls after the result is due. The clear pulse is counted on every falling clk_i edge over the whole frame plus the settling window, which catches both a missing pulse and a doubled one.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int WORD_W  = 16;
  localparam int N_CH    = 12;
  // control word fields
  localparam int C_SRR   = 15;
  localparam int C_OCS   = 14;
  // status word fields
  localparam int S_TP    = 15;
  localparam int S_PSF   = 14;
  localparam int S_OPL   = 13;
  localparam int S_SCD   = 12;
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic            ocs;
    logic [N_CH-1:0] ch;
  } ctrl_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_val_i,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= rst_val_i;
        else if (g == 0) chain_q[g] <= pin_i;
        else chain_q[g] <= chain_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= rst_val_i;
    else prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  input  logic  cs_fall_i,
  input  logic  cs_rise_i,
  input  logic  sck_rise_i,
  input  logic  sck_fall_i,
  input  logic  sdi_i,
  input  word_t status_i,
  output logic  sdo_bit_o,
  output word_t rx_word_o,
  output logic  commit_o
);
  word_t            tx_q, rx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      tx_q  <= status_i;
      cnt_q <= '0;
    end else if (active_i) begin
      if (sck_rise_i) begin
        rx_q <= {rx_q[WORD_W-2:0], sdi_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
      if (sck_fall_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_bit_o = tx_q[WORD_W-1];
  assign rx_word_o = rx_q;
  // only an exact-length frame commits
  assign commit_o  = cs_rise_i & active_i & (cnt_q == CNT_W'(WORD_W));

  AST_STATUS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> tx_q == $past(status_i));                                  // R4
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !sck_fall_i && !cs_fall_i) |=> $stable(tx_q));              // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX));                                               // R7
  AST_IDLE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(rx_q));                                            // R9
endmodule

// File: rtl/spi_ctrl_latch.sv
module spi_ctrl_latch
  import spi_stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  commit_i,
  input  word_t rx_word_i,
  output ctrl_t ctrl_o,
  output logic  srr_pulse_o
);
  ctrl_t ctrl_q;
  logic  pulse_q;
  logic  unused_rsvd;

  assign unused_rsvd = ^rx_word_i[C_OCS-1:N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= commit_i & rx_word_i[C_SRR];
      if (commit_i) begin
        ctrl_q.ocs <= rx_word_i[C_OCS];
        ctrl_q.ch  <= rx_word_i[N_CH-1:0];
      end
    end
  end

  assign ctrl_o      = ctrl_q;
  assign srr_pulse_o = pulse_q;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ctrl_q));                                          // R6
  AST_PULSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srr_pulse_o) |-> $past(commit_i));                                 // R8
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srr_pulse_o |=> !srr_pulse_o);                                           // R8
endmodule

// File: rtl/spi_stat_port.sv
module spi_stat_port
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csn_i,
  input  logic            sck_i,
  input  logic            sdi_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  input  logic            tp_i,
  input  logic            psf_i,
  input  logic            opl_i,
  input  logic            scd_i,
  input  logic [N_CH-1:0] ch_stat_i,
  output logic [N_CH-1:0] ch_on_o,
  output logic            ocs_en_o,
  output logic            srr_pulse_o
);
  logic  csn_lvl, cs_rise, cs_fall;
  logic  sck_lvl, sck_rise, sck_fall;
  logic  sdi_lvl, sdi_r_unused, sdi_f_unused;
  logic  csn_lvl_unused, sck_lvl_unused;
  logic  active_q, sdo_bit, commit;
  word_t status_w, rx_word;
  ctrl_t ctrl;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_csn (
    .clk_i, .rst_ni, .rst_val_i(1'b1), .pin_i(csn_i),
    .lvl_o(csn_lvl), .rise_o(cs_rise), .fall_o(cs_fall));
  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
    .clk_i, .rst_ni, .rst_val_i(1'b0), .pin_i(sck_i),
    .lvl_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));
  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (
    .clk_i, .rst_ni, .rst_val_i(1'b0), .pin_i(sdi_i),
    .lvl_o(sdi_lvl), .rise_o(sdi_r_unused), .fall_o(sdi_f_unused));

  assign csn_lvl_unused = csn_lvl;
  assign sck_lvl_unused = sck_lvl;

  always_comb begin
    status_w           = '0;
    status_w[S_TP]     = tp_i;
    status_w[S_PSF]    = psf_i;
    status_w[S_OPL]    = opl_i;
    status_w[S_SCD]    = scd_i;
    status_w[N_CH-1:0] = ch_stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (cs_fall) active_q <= 1'b1;
    else if (cs_rise) active_q <= 1'b0;
  end

  spi_shift_core u_core (
    .clk_i, .rst_ni,
    .active_i  (active_q),
    .cs_fall_i (cs_fall),
    .cs_rise_i (cs_rise),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .sdi_i     (sdi_lvl),
    .status_i  (status_w),
    .sdo_bit_o (sdo_bit),
    .rx_word_o (rx_word),
    .commit_o  (commit));

  spi_ctrl_latch u_ctrl (
    .clk_i, .rst_ni,
    .commit_i   (commit),
    .rx_word_i  (rx_word),
    .ctrl_o     (ctrl),
    .srr_pulse_o(srr_pulse_o));

  assign sdo_oe_o = active_q;
  assign sdo_o    = active_q & sdo_bit;
  assign ch_on_o  = ctrl.ch;
  assign ocs_en_o = ctrl.ocs;

  AST_OE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> sdo_oe_o);                                                   // R2
  AST_OE_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> !sdo_oe_o);                                                  // R2
  AST_CMD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o && !cs_rise |=> $stable(ch_on_o) && $stable(ocs_en_o));       // R9
endmodule

// File: tb/spi_stat_port_bench.sv
`timescale 1ns/1ps
module spi_stat_port_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic        tp = 0, psf = 0, opl = 0, scd = 0;
  logic [11:0] ch_stat = '0;
  logic        sdo, sdo_oe, ocs_en, srr_pulse;
  logic [11:0] ch_on;
  int          checks = 0, errors = 0, pulses = 0;
  logic [11:0] exp_ch = '0;
  logic        exp_ocs = 1'b0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  spi_stat_port u_spi_stat_port (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .tp_i(tp), .psf_i(psf), .opl_i(opl),
    .scd_i(scd), .ch_stat_i(ch_stat), .ch_on_o(ch_on), .ocs_en_o(ocs_en),
    .srr_pulse_o(srr_pulse));

  always @(negedge clk) if (srr_pulse) pulses++;

  function automatic logic [15:0] pack_status(logic t, logic p, logic o, logic s,
                                              logic [11:0] c);
    return {t, p, o, s, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_status();
    {tp, psf, opl, scd} = 4'($urandom);
    ch_stat = 12'($urandom);
  endtask

  // nb rising sck edges; rd holds bits read back
  task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] rd,
                      output logic [15:0] st);
    rd = '0;
    st = pack_status(tp, psf, opl, scd, ch_stat);
    csn = 1'b0;
    wclk(4);
    chk("R2 oe open", 32'(sdo_oe), 32'd1);
    rd[15] = sdo;
    rand_status();  // must not affect this frame (R4)
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'($urandom);
      wclk(4); sck = 1'b1;
      wclk(4); sck = 1'b0;
      wclk(4);
      if (i < 15) rd[14-i] = sdo;
    end
    csn = 1'b1; sdi = 1'b0;
    wclk(6);
  endtask

  task automatic frame(input logic [15:0] w, input int nb);
    logic [15:0] rd, st, mask;
    int p0, nr;
    p0 = pulses;
    xfer(w, nb, rd, st);
    nr = (nb + 1 > 16) ? 16 : nb + 1;
    mask = 16'hFFFF << (16 - nr);
    chk("R3 tp first", 32'(rd[15]), 32'(st[15]));
    chk("R4 status word", 32'(rd & mask), 32'(st & mask));
    if (nb == 16) begin
      exp_ch = w[11:0];
      exp_ocs = w[14];
    end
    chk(nb == 16 ? "R5 ch_on" : (nb < 16 ? "R6 ch_on" : "R7 ch_on"), 32'(ch_on), 32'(exp_ch));
    chk("R5 ocs_en", 32'(ocs_en), 32'(exp_ocs));
    chk("R8 pulse count", 32'(pulses - p0), 32'((nb == 16 && w[15]) ? 1 : 0));
    chk("R2 oe idle", 32'({sdo_oe, sdo}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wclk(3);
    chk("R1 reset ctrl", 32'({ch_on, ocs_en, srr_pulse, sdo_oe}), 32'd0);
    rst_n = 1'b1;
    wclk(2);
    chk("R1 after reset", 32'({ch_on, ocs_en, srr_pulse, sdo_oe, sdo}), 32'd0);
    // directed
    tp = 1; ch_stat = 12'hA5C;
    frame(16'h4FFF, 16);          // R5 full write, ocs set
    frame(16'hC123, 16);          // R8 srr set
    tp = 1; frame(16'h8000, 0);   // R6 tp-only read
    tp = 0; frame(16'h8000, 0);   // R3 tp low
    frame(16'hBABE, 15);          // R6 short by one
    frame(16'h8ABC, 17);          // R7 long by one
    frame(16'h3FFF, 16);          // R5 reserved bits ignored
    // R9: sck/sdi activity with select high
    for (int i = 0; i < 20; i++) begin
      sdi = 1'($urandom); wclk(4); sck = ~sck; wclk(4);
    end
    sck = 1'b0; wclk(6);
    chk("R9 idle ch_on", 32'(ch_on), 32'(exp_ch));
    chk("R9 idle oe", 32'({sdo_oe, sdo}), 32'd0);
    // random
    for (int k = 0; k < 40; k++) begin
      int nb;
      rand_status();
      nb = ($urandom % 4 != 0) ? 16 : int'($urandom % 21);
      frame(16'($urandom), nb);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule